// File: doc/BRIEF.md
# Non-Maskable Interrupt Flag Controller

The block gathers single-cycle error events from four detectors: oscillator failure, an error on the bus between the two processor subsystems, an uncorrectable RAM error and an uncorrectable flash error. Each event is latched into its own bit of a flag register, but only if that source's enable is set. A summary bit and one non-maskable interrupt are derived from the latched flags. The interrupt goes out on two identical outputs, one for each processor subsystem. A level output stays high while any flag remains latched, so that a downstream interrupt watchdog can time how long software takes to respond.

Software reaches three registers through a simple write port and a separate, combinational read port. Register 0 holds the flags and is read-only. Register 1 holds the enables, which are set-only. Register 2 clears flags when written. The oscillator-failure source is enabled out of reset. The other sources stay silent until software enables them. Once set, an enable bit can only be removed by reset. A `EDGE_MODE` parameter selects whether the source inputs are treated as pulses or as levels whose rising edge is the event.

Top module: `nmi_flag_ctrl`

## Requirements
- R1: After reset all flags are 0, the global bit is 0, the enable register reads the reset mask (default: only the oscillator-failure enable, bit 1, set, so register 1 reads 0x0002), and all three interrupt outputs are low.
- R2: A pulse on source i (0 = oscillator failure, 1 = inter-subsystem bus error, 2 = uncorrectable RAM, 3 = uncorrectable flash) while its enable is set latches flag bit i+1 of register 0. The flag is visible after the next rising clock edge.
- R3: A pulse on a source whose enable is clear leaves the flag register unchanged.
- R4: Writing register 1 ORs data bits 1..4 into the enables (bit i+1 enables source i). Writing 0 to a bit that is already enabled leaves it enabled.
- R5: Writing 1 to bit i+1 of register 2 clears flag i, and writing 0 leaves it unchanged. Register 2 always reads 0.
- R6: When a source event and a clear of the same flag happen in the same cycle, the flag stays set.
- R7: Bit 0 of register 0 is 1 exactly when at least one flag is set. It follows the flags in the same cycle.
- R8: `nmi_master_o` and `nmi_control_o` are always equal. They pulse high for one cycle when bit 0 of register 0 changes from 0 to 1.
- R9: `nmi_pending_o` equals bit 0 of register 0.
- R10: Writes to register 0 change nothing. Bit 0 written to register 1 or register 2 has no effect, and enable bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | NUM_SRC | Error events, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |
| nmi_master_o | output | 1 | Interrupt pulse to the master subsystem |
| nmi_control_o | output | 1 | Interrupt pulse to the control subsystem |
| nmi_pending_o | output | 1 | High while any flag is latched |

## Verification
The bench builds the block with its defaults: four sources, a 16-bit data path, pulse-mode inputs and a reset enable mask with only the oscillator-failure source enabled. The reset mask makes it possible to check that the bus-error and memory-error events are ignored before software enables them. Pulse mode lets a random event and a random clear land on the same flag in the same cycle, which exercises the priority of a set over a clear. The bench also checks the sticky enables and the single-cycle interrupt pulse on both outputs as flags come and go.

// File: rtl/nmi_flag_pkg.sv
package nmi_flag_pkg;

   localparam int REG_ADDR_W = 2;
   localparam int GLOBAL_BIT = 0;
   localparam int SRC_LSB    = 1;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_FLAG = 2'd0,
      REG_CFG  = 2'd1,
      REG_CLR  = 2'd2,
      REG_RSVD = 2'd3
   } nmi_reg_e;

endpackage

// File: rtl/nmi_flag_cell.sv
module nmi_flag_cell #(
   parameter bit EDGE_MODE = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic en_i,
   input  logic clr_i,
   output logic flag_nxt_o,
   output logic flag_o
);

   logic evt_seen;
   logic flag_q;

   generate
      if (EDGE_MODE) begin : g_edge
         logic evt_prev_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) evt_prev_q <= 1'b0;
            else         evt_prev_q <= evt_i;
         end
         assign evt_seen = evt_i & ~evt_prev_q;
      end else begin : g_pulse
         assign evt_seen = evt_i;
      end
   endgenerate

   // set has priority over clear
   always_comb begin
      flag_nxt_o = flag_q;
      if (clr_i)             flag_nxt_o = 1'b0;
      if (evt_seen && en_i)  flag_nxt_o = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_nxt_o;
   end

   assign flag_o = flag_q;

   p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_seen && en_i) |=> flag_o);

   p_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o && !en_i) |=> !flag_o);

   p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !evt_seen) |=> !flag_o);

   p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/nmi_enable_reg.sv
module nmi_enable_reg #(
   parameter int              NUM_SRC = 4,
   parameter logic [NUM_SRC-1:0] RST_EN  = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               set_we_i,
   input  logic [NUM_SRC-1:0] set_bits_i,
   output logic [NUM_SRC-1:0] en_o
);

   logic [NUM_SRC-1:0] en_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_bit
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                         en_q[gi] <= RST_EN[gi];
            else if (set_we_i && set_bits_i[gi]) en_q[gi] <= 1'b1;
         end

         p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_q[gi] |=> en_q[gi]);
      end
   endgenerate

   assign en_o = en_q;

endmodule

// File: rtl/nmi_reg_port.sv
module nmi_reg_port
   import nmi_flag_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NUM_SRC = 4
) (
   input  logic                  wr_en_i,
   input  logic [REG_ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   input  logic [REG_ADDR_W-1:0] rd_addr_i,
   input  logic [NUM_SRC-1:0]    flags_i,
   input  logic                  global_i,
   input  logic [NUM_SRC-1:0]    en_i,
   output logic                  cfg_we_o,
   output logic [NUM_SRC-1:0]    cfg_bits_o,
   output logic [NUM_SRC-1:0]    clr_bits_o,
   output logic [DATA_W-1:0]     rd_data_o
);

   localparam int SRC_MSB = SRC_LSB + NUM_SRC - 1;

   nmi_reg_e wr_sel;
   nmi_reg_e rd_sel;

   assign wr_sel     = nmi_reg_e'(wr_addr_i);
   assign rd_sel     = nmi_reg_e'(rd_addr_i);
   assign cfg_we_o   = wr_en_i && (wr_sel == REG_CFG);
   assign cfg_bits_o = wr_data_i[SRC_MSB:SRC_LSB];
   assign clr_bits_o = (wr_en_i && (wr_sel == REG_CLR)) ?
                       wr_data_i[SRC_MSB:SRC_LSB] : '0;

   always_comb begin
      rd_data_o = '0;
      unique case (rd_sel)
         REG_FLAG: begin
            rd_data_o[SRC_MSB:SRC_LSB] = flags_i;
            rd_data_o[GLOBAL_BIT]      = global_i;
         end
         REG_CFG:  rd_data_o[SRC_MSB:SRC_LSB] = en_i;
         REG_CLR:  rd_data_o = '0;
         REG_RSVD: rd_data_o = '0;
         default:  rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/nmi_flag_ctrl.sv
module nmi_flag_ctrl
   import nmi_flag_pkg::*;
#(
   parameter int                 NUM_SRC   = 4,
   parameter int                 DATA_W    = 16,
   parameter bit                 EDGE_MODE = 1'b0,
   parameter logic [NUM_SRC-1:0] RST_EN    = 4'b0001
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_SRC-1:0]    src_evt_i,
   input  logic                  wr_en_i,
   input  logic [REG_ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   input  logic [REG_ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0]     rd_data_o,
   output logic                  nmi_master_o,
   output logic                  nmi_control_o,
   output logic                  nmi_pending_o
);

   generate
      if (NUM_SRC < 1) begin : g_chk_src
         $error("NUM_SRC must be at least 1");
      end
      if (DATA_W < NUM_SRC + SRC_LSB) begin : g_chk_w
         $error("DATA_W too narrow for the flag field");
      end
   endgenerate

   logic [NUM_SRC-1:0] en;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] flags_nxt;
   logic [NUM_SRC-1:0] clr_bits;
   logic [NUM_SRC-1:0] cfg_bits;
   logic               cfg_we;
   logic               global_q;
   logic               nmi_q;

   nmi_reg_port #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC)
   ) u_port (
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .rd_addr_i  (rd_addr_i),
      .flags_i    (flags),
      .global_i   (global_q),
      .en_i       (en),
      .cfg_we_o   (cfg_we),
      .cfg_bits_o (cfg_bits),
      .clr_bits_o (clr_bits),
      .rd_data_o  (rd_data_o)
   );

   nmi_enable_reg #(
      .NUM_SRC (NUM_SRC),
      .RST_EN  (RST_EN)
   ) u_en (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_we_i   (cfg_we),
      .set_bits_i (cfg_bits),
      .en_o       (en)
   );

   genvar gs;
   generate
      for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
         nmi_flag_cell #(
            .EDGE_MODE (EDGE_MODE)
         ) u_cell (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .evt_i      (src_evt_i[gs]),
            .en_i       (en[gs]),
            .clr_i      (clr_bits[gs]),
            .flag_nxt_o (flags_nxt[gs]),
            .flag_o     (flags[gs])
         );
      end
   endgenerate

   // summary bit and edge-triggered interrupt, both aligned with the flags
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         global_q <= 1'b0;
         nmi_q    <= 1'b0;
      end else begin
         global_q <= |flags_nxt;
         nmi_q    <= (|flags_nxt) & ~global_q;
      end
   end

   assign nmi_master_o  = nmi_q;
   assign nmi_control_o = nmi_q;
   assign nmi_pending_o = global_q;

   p_global_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      global_q == (|flags));

   p_fanout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_master_o == nmi_control_o);

   p_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_master_o |=> !nmi_master_o);

   p_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(nmi_pending_o) |-> nmi_master_o);

   p_no_orphan_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_master_o |-> nmi_pending_o);

endmodule

// File: tb/nmi_flag_ctrl_tb.sv
module nmi_flag_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 4;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] evt = '0;
   logic          we = 1'b0;
   logic [1:0]    waddr = '0;
   logic [DW-1:0] wdata = '0;
   logic [1:0]    raddr = '0;
   logic [DW-1:0] rdata;
   logic          nmi_m, nmi_c, pend;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // model state
   logic [NS-1:0] m_flag, m_en;
   logic          m_glob, m_pulse;

   always #(CLK_PERIOD/2) clk = ~clk;

   nmi_flag_ctrl u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .src_evt_i     (evt),
      .wr_en_i       (we),
      .wr_addr_i     (waddr),
      .wr_data_i     (wdata),
      .rd_addr_i     (raddr),
      .rd_data_o     (rdata),
      .nmi_master_o  (nmi_m),
      .nmi_control_o (nmi_c),
      .nmi_pending_o (pend)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_flag_reg(logic [NS-1:0] f);
      return {{(DW-NS-1){1'b0}}, f, |f};
   endfunction

   function automatic logic [DW-1:0] exp_cfg_reg(logic [NS-1:0] e);
      return {{(DW-NS-1){1'b0}}, e, 1'b0};
   endfunction

   task automatic check_all(input string tag);
      raddr = 2'd0; #1;
      chk({tag, " R2/R7 flag reg"}, 32'(rdata), 32'(exp_flag_reg(m_flag)));
      raddr = 2'd1; #1;
      chk({tag, " R4/R10 cfg reg"}, 32'(rdata), 32'(exp_cfg_reg(m_en)));
      raddr = 2'd2; #1;
      chk({tag, " R5 clr reads 0"}, 32'(rdata), 32'd0);
      chk({tag, " R8 nmi master"}, 32'(nmi_m), 32'(m_pulse));
      chk({tag, " R8 nmi control"}, 32'(nmi_c), 32'(m_pulse));
      chk({tag, " R9 pending"}, 32'(pend), 32'(m_glob));
   endtask

   task automatic cycle(input logic [NS-1:0] e, input logic w, input logic [1:0] a,
                        input logic [DW-1:0] d, input string tag);
      logic [NS-1:0] nf, ne;
      @(negedge clk);
      evt = e; we = w; waddr = a; wdata = d;
      nf = m_flag;
      if (w && a == 2'd2) nf = nf & ~d[NS:1];
      nf = nf | (e & m_en);
      ne = m_en;
      if (w && a == 2'd1) ne = ne | d[NS:1];
      @(posedge clk); #1;
      m_pulse = (|nf) & ~m_glob;
      m_flag = nf; m_en = ne; m_glob = |nf;
      evt = '0; we = 1'b0;
      check_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_flag = '0; m_en = 4'b0001; m_glob = 1'b0; m_pulse = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 reset");
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check_all("R1 after release");

      // R3: disabled bus-error / memory sources are ignored
      cycle(4'b1110, 1'b0, 2'd0, '0, "R3 disabled sources");
      // R2: oscillator failure latches bit 1, R8 pulse
      cycle(4'b0001, 1'b0, 2'd0, '0, "R2 clock fail");
      cycle(4'b0000, 1'b0, 2'd0, '0, "R8 pulse ends");
      // R4: writing zero does not disable
      cycle(4'b0000, 1'b1, 2'd1, 16'h0000, "R4 write zero");
      // R10: write to flag register ignored
      cycle(4'b0000, 1'b1, 2'd0, 16'hFFFF, "R10 flag write");
      // R10: bit 0 of clear ignored
      cycle(4'b0000, 1'b1, 2'd2, 16'h0001, "R10 clr bit0");
      // R5: zero clear has no effect, then clear
      cycle(4'b0000, 1'b1, 2'd2, 16'h0000, "R5 clear zero");
      cycle(4'b0000, 1'b1, 2'd2, 16'h0002, "R5 R7 clear all");
      // R4: enable bus error
      cycle(4'b0000, 1'b1, 2'd1, 16'h0005, "R4 enable bus error");
      cycle(4'b0010, 1'b0, 2'd0, '0, "R2 bus error");
      // R6: event and clear collide
      cycle(4'b0010, 1'b1, 2'd2, 16'h0004, "R6 set beats clear");
      cycle(4'b0000, 1'b1, 2'd1, 16'h001E, "R4 enable all");
      cycle(4'b1100, 1'b0, 2'd0, '0, "R2 memory errors");
      cycle(4'b0000, 1'b1, 2'd2, 16'h0004, "R7 partial clear");
      cycle(4'b0000, 1'b1, 2'd2, 16'h001E, "R7 full clear");
      cycle(4'b0001, 1'b0, 2'd0, '0, "R8 re-raise");

      for (int i = 0; i < 3000; i++) begin
         logic [NS-1:0] re;
         logic [1:0]    ra;
         logic          rw;
         re = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
         rw = ($urandom_range(0, 2) == 0);
         ra = 2'($urandom);
         cycle(re, rw, ra, DW'($urandom), "R6 random");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule